// File: doc/BRIEF.md
# Color Lookup Table Host Port

This block is the processor-facing side of a 256-entry color lookup table. A host reaches all of its storage through one byte-wide data path, a chip enable, a read/write select and a two-bit target select. An internal 8-bit pointer and a two-bit color phase counter walk the host through red, green and blue bytes. The block stores the 256 x 24-bit palette, four 24-bit overlay colors and four byte-wide control registers: pixel read mask, blink mask, command and a diagnostic register.

A second, independent port serves the display pipeline. Each cycle it looks up either a palette entry or an overlay color and presents the 24-bit result one clock later. Host updates never stall it. The mask and command registers are driven out as plain outputs for the neighbouring pixel logic.

All signals, including the chip enable, are sampled in the system clock domain. The falling edge of the chip enable opens an access and latches the command. The rising edge closes the access and commits its effect.

Top module: `pal_host_ctrl`

## Requirements
- R1: `bus_sel` picks the target of an access: 2'b00 is the pointer, 2'b01 is the palette, 2'b11 is the overlay colors and 2'b10 is the control registers.
- R2: Any read or write with target 2'b00 returns the phase counter to red. A write also loads `bus_din` into the pointer, and a read returns the pointer value.
- R3: Palette and overlay accesses move through the phases red (bits 23:16), green (bits 15:8), blue (bits 7:0) and then back to red. Red and green write bytes are only staged. The stored 24-bit word changes only when the blue byte is written.
- R4: After each blue palette access, read or write, the pointer advances by one, wrapping from 8'hFF to 8'h00.
- R5: Overlay colors sit at pointer values 0 to 3. A blue access at 3 moves the pointer to 4.
- R6: Control registers sit at pointer values 4 (read mask), 5 (blink mask), 6 (command) and 7 (diagnostic). Accessing them leaves both the pointer and the phase unchanged. The first three drive `ctl_rmask`, `ctl_bmask` and `ctl_cmd`.
- R7: If the pointer is outside the range of an overlay or control access, a write changes no state at all (storage, pointer and phase), and a read returns 8'h00.
- R8: The diagnostic register keeps only bits 3:0. Reading it returns those bits on 3:0. Bits 7:4 carry a nibble of the current `disp_data`: red, green or blue when the stored bits 2:0 are 3'b001, 3'b010 or 3'b100, and 4'h0 for any other code. Stored bit 3 set picks the upper nibble of that color; clear picks the lower nibble.
- R9: Select and direction are latched at the first clock edge that sees `bus_cs_n` low. `bus_din` is taken at the first edge that sees it high again. `bus_oe` is high, and `bus_dout` carries read data, for a read only, from the edge after `bus_cs_n` falls through the edge that sees it rise.
- R10: `disp_data` shows, one clock after its address inputs, either overlay color `disp_ovl_idx` (when `disp_ovl` is 1) or palette entry `disp_addr`. It is never held off by host accesses.
- R11: After reset the pointer is 0, the phase is red, the overlay colors and control registers are 0, and `bus_oe`, `bus_dout` and `disp_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs_n | input | 1 | Host chip enable, active low |
| bus_rd_wn | input | 1 | 1 = read, 0 = write |
| bus_sel | input | 2 | Target select |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data, 0 when not driving |
| bus_oe | output | 1 | Output enable for the external data pad |
| disp_addr | input | 8 | Display-side palette index |
| disp_ovl | input | 1 | Display-side overlay select |
| disp_ovl_idx | input | 2 | Display-side overlay index |
| disp_data | output | 24 | Display-side color {red, green, blue} |
| ctl_rmask | output | 8 | Pixel read mask |
| ctl_bmask | output | 8 | Blink mask |
| ctl_cmd | output | 8 | Command byte |

## Verification
A host access has two fixed moments. Its read byte and `bus_oe` appear one clock after the edge that sees `bus_cs_n` low. Its state change lands on the edge that sees `bus_cs_n` high again. The bench drives the bus on falling clock edges, samples read data at the falling edge after the access opens, and updates its reference model at the closing rising edge. Display results are due one clock after their address: the bench forms the expected color just before each rising edge and compares `disp_data` and the control outputs 1 ns after that edge.

// File: rtl/pal_pkg.sv
// Shared encodings for the color lookup table host port.
// Assumes the control block follows directly after the overlay block in the
// pointer space, with a size that is a multiple of four.
package pal_pkg;

    // Host target select, as driven on bus_sel.
    typedef enum logic [1:0] {
        TGT_PTR = 2'b00,
        TGT_PAL = 2'b01,
        TGT_CTL = 2'b10,
        TGT_OVL = 2'b11
    } tgt_e;

    // Control register index, counted from the start of the control block.
    typedef enum logic [1:0] {
        CTL_RMASK = 2'd0,
        CTL_BMASK = 2'd1,
        CTL_CMD   = 2'd2,
        CTL_DIAG  = 2'd3
    } ctl_e;

    // Color phase of a three-byte access.
    localparam logic [1:0] PH_RED   = 2'd0;
    localparam logic [1:0] PH_GREEN = 2'd1;
    localparam logic [1:0] PH_BLUE  = 2'd2;

endpackage

// File: rtl/pal_bus_if.sv
// Host strobe front end. Detects the open and close of an access from the
// sampled chip enable, latches the command when the access opens, and gives a
// one-cycle commit pulse when it closes. Assumes every input is synchronous
// to clk.
module pal_bus_if
    import pal_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_wn,
    input  tgt_e              sel,
    input  logic [DATA_W-1:0] din,
    output logic              go,
    output logic              op_rd,
    output tgt_e              op_sel,
    output logic [DATA_W-1:0] wdata,
    output logic              oe
);
    logic act;

    // Track an open access and hold its command for its whole length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= 1'b0;
            op_rd  <= 1'b1;
            op_sel <= TGT_PTR;
        end else if (!act && !cs_n) begin
            act    <= 1'b1;
            op_rd  <= rd_wn;
            op_sel <= sel;
        end else if (act && cs_n) begin
            act    <= 1'b0;
        end
    end

    assign go    = act & cs_n;
    assign wdata = din;
    assign oe    = act & op_rd;
endmodule

// File: rtl/pal_addr_seq.sv
// Pointer and color phase sequencer. Checks that the pointer is valid for the
// latched target, stages red and green write bytes, and issues the write
// strobes for palette, overlay and control storage. Assumes ADDR_W <= DATA_W.
module pal_addr_seq
    import pal_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int OVL_N  = 4,
    parameter int CTL_N  = 4
) (
    input  logic                 clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                op_rd,
    input  tgt_e                op_sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic [ADDR_W-1:0]   addr,
    output logic [1:0]          phase,
    output logic                valid,
    output logic                pal_we,
    output logic                ovl_we,
    output logic                ctl_we,
    output logic [3*DATA_W-1:0] wword
);
    localparam logic [ADDR_W-1:0] OVL_END = ADDR_W'(OVL_N);
    localparam logic [ADDR_W-1:0] CTL_END = ADDR_W'(OVL_N + CTL_N);

    logic [DATA_W-1:0] hold_r, hold_g;
    logic              is_color, last, commit;

    // Decide whether the pointer addresses something for this target.
    always_comb begin
        unique case (op_sel)
            TGT_OVL: valid = (addr < OVL_END);
            TGT_CTL: valid = (addr >= OVL_END) && (addr < CTL_END);
            default: valid = 1'b1;
        endcase
    end

    assign is_color = (op_sel == TGT_PAL) || (op_sel == TGT_OVL);
    assign last     = (phase == PH_BLUE);
    assign commit   = go && valid && !op_rd && is_color && last;
    assign pal_we   = commit && (op_sel == TGT_PAL);
    assign ovl_we   = commit && (op_sel == TGT_OVL);
    assign ctl_we   = go && valid && !op_rd && (op_sel == TGT_CTL);
    assign wword    = {hold_r, hold_g, wdata};

    // Advance pointer and phase, and stage the red and green bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            phase  <= PH_RED;
            hold_r <= '0;
            hold_g <= '0;
        end else if (go && valid) begin
            if (op_sel == TGT_PTR) begin
                if (!op_rd) addr <= wdata[ADDR_W-1:0];
                phase <= PH_RED;
            end else if (is_color) begin
                if (!op_rd && phase == PH_RED)   hold_r <= wdata;
                if (!op_rd && phase == PH_GREEN) hold_g <= wdata;
                if (last) begin
                    phase <= PH_RED;
                    addr  <= addr + 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pal_color_store.sv
// Palette array and overlay colors. The host side is written on commit and
// read without delay; the display side has its own registered read port.
// A display read in the same cycle as a write to that location sees the old
// word.
module pal_color_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int OVL_N  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pal_we,
    input  logic                      ovl_we,
    input  logic [ADDR_W-1:0]         haddr,
    input  logic [3*DATA_W-1:0]       wword,
    input  logic [ADDR_W-1:0]         disp_addr,
    input  logic                      disp_ovl,
    input  logic [$clog2(OVL_N)-1:0]  disp_ovl_idx,
    output logic [3*DATA_W-1:0]       host_pal,
    output logic [3*DATA_W-1:0]       host_ovl,
    output logic [3*DATA_W-1:0]       disp_data
);
    localparam int WORD_W = 3 * DATA_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int OIW    = $clog2(OVL_N);

    logic [WORD_W-1:0] pal_mem [DEPTH];
    logic [WORD_W-1:0] ovl_reg [OVL_N];

    // Palette write port; the array itself is not reset.
    always_ff @(posedge clk) begin
        if (pal_we) pal_mem[haddr] <= wword;
    end

    // One register per overlay color, each with its own write decode.
    for (genvar g = 0; g < OVL_N; g++) begin : g_ovl
        always_ff @(posedge clk) begin
            if (!rst_n)                                  ovl_reg[g] <= '0;
            else if (ovl_we && haddr[OIW-1:0] == OIW'(g)) ovl_reg[g] <= wword;
        end
    end

    assign host_pal = pal_mem[haddr];
    assign host_ovl = ovl_reg[haddr[OIW-1:0]];

    // Display lookup with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n)        disp_data <= '0;
        else if (disp_ovl) disp_data <= ovl_reg[disp_ovl_idx];
        else               disp_data <= pal_mem[disp_addr];
    end
endmodule

// File: rtl/pal_ctrl_regs.sv
// Mask, command and diagnostic registers with their read-back. The
// diagnostic register keeps its low half only and reports one nibble of the
// display color chosen by its stored bits.
module pal_ctrl_regs
    import pal_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  ctl_e                idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [3*DATA_W-1:0] disp_word,
    output logic [DATA_W-1:0]   rmask,
    output logic [DATA_W-1:0]   bmask,
    output logic [DATA_W-1:0]   cmd,
    output logic [DATA_W-1:0]   rdata
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0]   diag;
    logic [DATA_W-1:0] chan;
    logic [HALF-1:0]   nib;

    // Register writes from the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmask <= '0;
            bmask <= '0;
            cmd   <= '0;
            diag  <= '0;
        end else if (we) begin
            unique case (idx)
                CTL_RMASK: rmask <= wdata;
                CTL_BMASK: bmask <= wdata;
                CTL_CMD:   cmd   <= wdata;
                CTL_DIAG:  diag  <= wdata[HALF-1:0];
            endcase
        end
    end

    // Pick the color channel and nibble for the diagnostic read-back.
    always_comb begin
        unique case (diag[2:0])
            3'b001:  chan = disp_word[3*DATA_W-1:2*DATA_W];
            3'b010:  chan = disp_word[2*DATA_W-1:DATA_W];
            3'b100:  chan = disp_word[DATA_W-1:0];
            default: chan = '0;
        endcase
        nib = diag[3] ? chan[DATA_W-1:HALF] : chan[HALF-1:0];
    end

    // Read-back multiplexer.
    always_comb begin
        unique case (idx)
            CTL_RMASK: rdata = rmask;
            CTL_BMASK: rdata = bmask;
            CTL_CMD:   rdata = cmd;
            CTL_DIAG:  rdata = {nib, diag};
        endcase
    end
endmodule

// File: rtl/pal_host_ctrl.sv
// Color lookup table host port: strobe front end, pointer sequencer, color
// storage with a display read port, and control registers. Assumes
// synchronous host signals, ADDR_W equal to DATA_W, and OVL_N equal to 4.
module pal_host_ctrl
    import pal_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int OVL_N  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_cs_n,
    input  logic                      bus_rd_wn,
    input  logic [1:0]                bus_sel,
    input  logic [DATA_W-1:0]         bus_din,
    output logic [DATA_W-1:0]         bus_dout,
    output logic                      bus_oe,
    input  logic [ADDR_W-1:0]         disp_addr,
    input  logic                      disp_ovl,
    input  logic [$clog2(OVL_N)-1:0]  disp_ovl_idx,
    output logic [3*DATA_W-1:0]       disp_data,
    output logic [DATA_W-1:0]         ctl_rmask,
    output logic [DATA_W-1:0]         ctl_bmask,
    output logic [DATA_W-1:0]         ctl_cmd
);
    localparam int WORD_W = 3 * DATA_W;
    localparam int CTL_N  = 4;

    logic              go, op_rd, oe, valid, pal_we, ovl_we, ctl_we;
    tgt_e              op_sel;
    logic [DATA_W-1:0] wdata, ctl_rdata, rd_byte;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        phase;
    logic [WORD_W-1:0] wword, host_pal, host_ovl, color_word;

    pal_bus_if #(.DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .rd_wn(bus_rd_wn),
        .sel(tgt_e'(bus_sel)), .din(bus_din), .go(go), .op_rd(op_rd),
        .op_sel(op_sel), .wdata(wdata), .oe(oe)
    );

    pal_addr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVL_N(OVL_N), .CTL_N(CTL_N)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .op_rd(op_rd), .op_sel(op_sel),
        .wdata(wdata), .addr(addr), .phase(phase), .valid(valid),
        .pal_we(pal_we), .ovl_we(ovl_we), .ctl_we(ctl_we), .wword(wword)
    );

    pal_color_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVL_N(OVL_N)) u_store (
        .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .ovl_we(ovl_we),
        .haddr(addr), .wword(wword), .disp_addr(disp_addr), .disp_ovl(disp_ovl),
        .disp_ovl_idx(disp_ovl_idx), .host_pal(host_pal), .host_ovl(host_ovl),
        .disp_data(disp_data)
    );

    pal_ctrl_regs #(.DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .idx(ctl_e'(addr[1:0])),
        .wdata(wdata), .disp_word(disp_data), .rmask(ctl_rmask),
        .bmask(ctl_bmask), .cmd(ctl_cmd), .rdata(ctl_rdata)
    );

    // Choose the byte of the addressed color word for the current phase.
    always_comb begin
        color_word = (op_sel == TGT_OVL) ? host_ovl : host_pal;
        unique case (op_sel)
            TGT_PTR: rd_byte = DATA_W'(addr);
            TGT_PAL, TGT_OVL: begin
                if (!valid)                rd_byte = '0;
                else if (phase == PH_RED)  rd_byte = color_word[WORD_W-1:2*DATA_W];
                else if (phase == PH_GREEN) rd_byte = color_word[2*DATA_W-1:DATA_W];
                else                        rd_byte = color_word[DATA_W-1:0];
            end
            TGT_CTL: rd_byte = valid ? ctl_rdata : '0;
        endcase
    end

    assign bus_oe   = oe;
    assign bus_dout = oe ? rd_byte : '0;
endmodule

// File: rtl/pal_host_ctrl_chk.sv
// Temporal checks on the host port sequencing, attached to every instance of
// the top module.
module pal_host_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int OVL_N  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe,
    input logic              go,
    input logic [1:0]        op_sel,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        phase
);
    localparam logic [ADDR_W-1:0] OVL_END = ADDR_W'(OVL_N);
    localparam logic [ADDR_W-1:0] LAST_OVL = ADDR_W'(OVL_N - 1);

    p_oe_needs_low_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> $past(!cs_n));

    p_ptr_clears_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'b00) |=> (phase == 2'd0));

    p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);

    p_pal_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'b01 && phase == 2'd2 && addr == '1) |=> (addr == '0 && phase == 2'd0));

    p_ovl_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'b11 && phase == 2'd2 && addr == LAST_OVL) |=> (addr == OVL_END));

    p_ctl_holds_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'b10) |=> ($stable(addr) && $stable(phase)));

    p_ovl_invalid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'b11 && addr >= OVL_END) |=> ($stable(addr) && $stable(phase)));
endmodule

bind pal_host_ctrl pal_host_ctrl_chk #(.ADDR_W(ADDR_W), .OVL_N(OVL_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .oe(bus_oe), .go(go),
    .op_sel(op_sel), .addr(addr), .phase(phase)
);

// File: tb/pal_host_ctrl_test.sv
// Self-checking bench with a behavioural reference model of the host port.
module pal_host_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_rd_wn = 1'b1;
    logic [1:0]  bus_sel = 2'b00;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [7:0]  disp_addr = 8'h00;
    logic        disp_ovl = 1'b0;
    logic [1:0]  disp_ovl_idx = 2'd0;
    logic [23:0] disp_data;
    logic [7:0]  ctl_rmask, ctl_bmask, ctl_cmd;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    int  m_pal [256];
    bit  m_known [256];
    int  m_ovl [4];
    int  m_ctl [4];
    int  m_addr = 0, m_phase = 0, m_hr = 0, m_hg = 0;
    int  pend = 0, last_disp = 0;
    bit  pend_ok = 1'b0, last_ok = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    pal_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_wn(bus_rd_wn),
        .bus_sel(bus_sel), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .disp_addr(disp_addr), .disp_ovl(disp_ovl), .disp_ovl_idx(disp_ovl_idx),
        .disp_data(disp_data), .ctl_rmask(ctl_rmask), .ctl_bmask(ctl_bmask),
        .ctl_cmd(ctl_cmd)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int byte_of(input int w, input int ph);
        return (w >> (8 * (2 - ph))) & 8'hFF;
    endfunction

    function automatic int model_read(input int sel);
        int t, c, nib;
        case (sel)
            0: return m_addr;
            1: return byte_of(m_pal[m_addr], m_phase);
            3: return (m_addr < 4) ? byte_of(m_ovl[m_addr], m_phase) : 0;
            default: begin
                if (m_addr < 4 || m_addr > 7) return 0;
                if (m_addr < 7) return m_ctl[m_addr - 4];
                t = m_ctl[3];
                case (t & 7)
                    1: c = (last_disp >> 16) & 8'hFF;
                    2: c = (last_disp >> 8) & 8'hFF;
                    4: c = last_disp & 8'hFF;
                    default: c = 0;
                endcase
                nib = (t & 8) ? (c >> 4) : (c & 15);
                return (nib << 4) | t;
            end
        endcase
    endfunction

    task automatic model_apply(input bit rd, input int sel, input int data);
        bit ok;
        if (sel == 0) begin
            if (!rd) m_addr = data;
            m_phase = 0;
        end else if (sel == 2) begin
            if (!rd && m_addr >= 4 && m_addr <= 7)
                m_ctl[m_addr - 4] = (m_addr == 7) ? (data & 15) : data;
        end else begin
            ok = (sel == 1) || (m_addr < 4);
            if (ok) begin
                if (!rd && m_phase == 0) m_hr = data;
                if (!rd && m_phase == 1) m_hg = data;
                if (m_phase == 2) begin
                    if (!rd && sel == 1) begin
                        m_pal[m_addr] = (m_hr << 16) | (m_hg << 8) | data;
                        m_known[m_addr] = 1'b1;
                    end
                    if (!rd && sel == 3) m_ovl[m_addr] = (m_hr << 16) | (m_hg << 8) | data;
                    m_phase = 0;
                    m_addr = (m_addr + 1) & 255;
                end else begin
                    m_phase++;
                end
            end
        end
    endtask

    // One host access: open on a falling edge, close one cycle later.
    task automatic acc(input bit rd, input int sel, input int data, input string req);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_rd_wn = rd; bus_sel = sel[1:0];
        bus_din = ~data[7:0];
        check(bus_oe == 1'b0, "R9 oe before open", bus_oe, 0);
        @(negedge clk);
        check(bus_oe == rd, "R9 oe during access", bus_oe, rd);
        if (rd) check(bus_dout == model_read(sel), req, bus_dout, model_read(sel));
        bus_cs_n = 1'b1; bus_din = data[7:0];
        @(posedge clk);
        model_apply(rd, sel, data);
        @(negedge clk);
        check(bus_oe == 1'b0, "R9 oe after close", bus_oe, 0);
    endtask

    task automatic wr3(input int sel, input int w, input string req);
        acc(1'b0, sel, (w >> 16) & 255, req);
        acc(1'b0, sel, (w >> 8) & 255, req);
        acc(1'b0, sel, w & 255, req);
    endtask

    task automatic rd3(input int sel, input string req);
        for (int k = 0; k < 3; k++) acc(1'b1, sel, 0, req);
    endtask

    // Expected display word, formed before each rising edge (R10).
    always @(negedge clk) begin
        #1;
        if (disp_ovl) begin
            pend = m_ovl[disp_ovl_idx]; pend_ok = 1'b1;
        end else begin
            pend = m_pal[disp_addr]; pend_ok = m_known[disp_addr];
        end
    end

    // Per-clock comparison of display data and control outputs (R10, R6).
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (pend_ok) check(disp_data == pend[23:0], "R10 display word", disp_data, pend);
            last_disp = pend; last_ok = pend_ok;
            check(ctl_rmask == m_ctl[0][7:0], "R6 read mask out", ctl_rmask, m_ctl[0]);
            check(ctl_bmask == m_ctl[1][7:0], "R6 blink mask out", ctl_bmask, m_ctl[1]);
            check(ctl_cmd == m_ctl[2][7:0], "R6 command out", ctl_cmd, m_ctl[2]);
        end
    end

    // Display-side stimulus, independent of the host.
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            disp_addr = lfsr[9:2];
            disp_ovl = lfsr[15] & lfsr[14];
            disp_ovl_idx = lfsr[1:0];
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin m_pal[i] = 0; m_known[i] = 1'b0; end
        for (int i = 0; i < 4; i++) begin m_ovl[i] = 0; m_ctl[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports.
        check(bus_oe == 1'b0, "R11 oe reset", bus_oe, 0);
        check(bus_dout == 8'h00, "R11 dout reset", bus_dout, 0);
        check(disp_data == 24'h0, "R11 display reset", disp_data, 0);
        check(ctl_rmask == 8'h00 && ctl_cmd == 8'h00, "R11 control reset", ctl_cmd, 0);
        acc(1'b1, 0, 0, "R11 pointer reset");
        acc(1'b1, 3, 0, "R11 overlay reset");

        // R1, R3, R4: fill the palette from 0, pointer wraps back to 0.
        acc(1'b0, 0, 0, "R2 load pointer");
        for (int i = 0; i < 256; i++)
            wr3(1, (i << 16) | ((i ^ 8'h5A) << 8) | (255 - i), "R3 fill");
        acc(1'b1, 0, 0, "R4 wrap after write");
        rd3(1, "R1 palette read");
        acc(1'b0, 0, 8'hFF, "R2 load pointer");
        rd3(1, "R3 read top entry");
        acc(1'b1, 0, 0, "R4 wrap after read");

        // R3: red and green alone do not commit.
        acc(1'b0, 0, 8'h20, "R2 load pointer");
        acc(1'b0, 1, 8'h11, "R3 stage red");
        acc(1'b0, 1, 8'h22, "R3 stage green");
        acc(1'b0, 0, 8'h20, "R2 reload clears phase");
        rd3(1, "R3 no commit before blue");
        acc(1'b0, 0, 8'h20, "R2 load pointer");
        wr3(1, 24'hABCDEF, "R3 commit");
        acc(1'b0, 0, 8'h20, "R2 load pointer");
        rd3(1, "R3 committed word");

        // R2: a pointer read clears a half-done phase.
        acc(1'b0, 0, 8'h30, "R2 load pointer");
        acc(1'b0, 1, 8'h77, "R2 partial red");
        acc(1'b1, 0, 0, "R2 pointer read");
        wr3(1, 24'h010203, "R2 fresh triple");
        acc(1'b1, 0, 0, "R2 pointer advanced");
        acc(1'b0, 0, 8'h30, "R2 load pointer");
        rd3(1, "R2 triple stored");

        // R5: overlay colors 2 and 3, then the pointer leaves to 4.
        acc(1'b0, 0, 2, "R5 load pointer");
        wr3(3, 24'h123456, "R5 overlay 2");
        wr3(3, 24'hFEDCBA, "R5 overlay 3");
        acc(1'b1, 0, 0, "R5 pointer after overlay 3");
        acc(1'b0, 0, 0, "R5 load pointer");
        for (int i = 0; i < 4; i++) rd3(3, "R5 overlay read");
        acc(1'b1, 0, 0, "R5 pointer after overlay reads");

        // R7: overlay access with the pointer at 4 is ignored.
        acc(1'b0, 3, 8'h55, "R7 ignored overlay write");
        acc(1'b1, 3, 0, "R7 invalid overlay read");
        acc(1'b1, 0, 0, "R7 pointer unchanged");

        // R6, R8: control registers and the diagnostic read-back.
        acc(1'b0, 2, 8'hA5, "R6 read mask write");
        acc(1'b1, 0, 0, "R6 no increment");
        acc(1'b1, 2, 0, "R6 read mask back");
        acc(1'b0, 0, 5, "R6 load pointer");
        acc(1'b0, 2, 8'h3C, "R6 blink mask write");
        acc(1'b0, 0, 6, "R6 load pointer");
        acc(1'b0, 2, 8'h81, "R6 command write");
        acc(1'b1, 2, 0, "R6 command back");
        acc(1'b0, 0, 7, "R8 load pointer");
        acc(1'b0, 2, 8'hF3, "R8 low half only");
        acc(1'b1, 2, 0, "R8 no channel code");
        acc(1'b0, 2, 8'h09, "R8 red upper");
        acc(1'b1, 2, 0, "R8 red upper read");
        acc(1'b0, 2, 8'h02, "R8 green lower");
        acc(1'b1, 2, 0, "R8 green lower read");
        acc(1'b0, 2, 8'h0C, "R8 blue upper");
        acc(1'b1, 2, 0, "R8 blue upper read");

        // R7: control access out of range is ignored.
        acc(1'b0, 0, 8'h10, "R7 load pointer");
        acc(1'b0, 2, 8'hEE, "R7 ignored control write");
        acc(1'b1, 2, 0, "R7 invalid control read");
        acc(1'b0, 0, 4, "R7 load pointer");
        acc(1'b1, 2, 0, "R7 read mask kept");

        repeat (64) @(negedge clk);
        finish_run();
    end
endmodule